// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the command and data path of a byte-wide serial memory slave with 2048 locations of 8 bits, held in an internal register array. An SPI front end delivers one sampled data-in bit with a strobe for each rising clock edge, a strobe for each falling edge, and the chip-select level. The engine treats the first byte of each selected frame as the command. It gathers a two-byte start address, runs read and write bursts of any length with a wrapping address counter, and shifts read data out most significant bit first.

Write permission is not decided here. A separate protection unit sees the address under the counter and answers with an allow flag. It receives one-cycle pulses to set or clear its write latch, and it receives status-register write requests. The engine returns that unit's status byte on a status read. Writes take effect at bus speed. There is no page buffer and no busy state.

Top module: `scmd_engine`

## Requirements
- R1: Command byte 0x06 gives one pulse on `set_wel_o` and byte 0x04 gives one pulse on `clr_wel_o`. Each pulse lasts one cycle and comes in the cycle after the rising-edge strobe of the command's eighth bit.
- R2: Only the first byte after chip select goes active is decoded. Later bytes in the same frame are never taken as commands.
- R3: Commands 0x03 (read) and 0x02 (write) take a 16-bit address, most significant bit first. Only its low 11 bits select the start location, and the top 5 bits have no effect.
- R4: On a write, each data byte is stored at the counter address once its eighth bit has been sampled, and a later read returns it.
- R5: On a read, data leaves on `miso_o` MSB first, with `miso_oe_o` high. The first bit appears on the falling edge after the last address bit, and each later byte starts on the falling edge after the previous byte's eighth bit. Data-in bits sent during the read change nothing.
- R6: The address goes up by one after every data byte. It wraps from 0x7FF to 0x000, and a burst has no length limit.
- R7: A write byte whose address the protection unit refuses (`wr_allow_i` low) is dropped. The address still advances to the next location.
- R8: Command 0x05 returns the `status_i` byte once, MSB first. On the falling edge after that byte's eighth bit, the output is released (`miso_oe_o` low).
- R9: Command 0x01 takes one byte and gives one pulse on `sts_wr_o` with that byte on `sts_wdata_o`. When a frame that held command 0x01 or 0x02 is deselected, `clr_wel_o` pulses once.
- R10: An unknown command makes the engine ignore the rest of the frame: no memory change, no pulse, and the output stays undriven. While undriven, `miso_o` is 0.
- R11: Deselecting ends a frame at once. An incomplete data byte is not stored, and the next frame is decoded from its first bit.
- R12: Edge strobes and data-in bits while chip select is inactive have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select, active high, from the front end |
| sck_rise_i | input | 1 | One-cycle strobe per serial-clock rising edge |
| sck_fall_i | input | 1 | One-cycle strobe per serial-clock falling edge |
| mosi_i | input | 1 | Data-in bit, valid with the rising strobe |
| wr_allow_i | input | 1 | Protection unit permits a write at `chk_addr_o` |
| status_i | input | 8 | Status byte returned by command 0x05 |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Data-out drive enable |
| chk_addr_o | output | 11 | Address under the burst counter |
| set_wel_o | output | 1 | Pulse: set the write latch |
| clr_wel_o | output | 1 | Pulse: clear the write latch |
| sts_wr_o | output | 1 | Pulse: status write request |
| sts_wdata_o | output | 8 | Byte for the status write |

## Verification
The pulse outputs appear one clock after the rising strobe that completes a byte, or one clock after chip select drops. The bench therefore counts them with edge counters and reads the counts only after the frame is closed and several idle cycles have passed. A memory write lands on the clock edge of its byte's last rising strobe. Read bits are registered on the falling-strobe cycle, so the bench samples `miso_o` on the falling clock edge just before the next rising strobe, two cycles after the bit was presented. Read bytes go into a received queue, and a monitor compares them against the expected bytes that the driver queued before the frame.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADH,
        PH_ADL,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LATCH_ON,
        CMD_LATCH_OFF,
        CMD_STS_RD,
        CMD_STS_WR,
        CMD_MEM_RD,
        CMD_MEM_WR
    } cmd_e;
endpackage

// File: rtl/scmd_decode.sv
module scmd_decode
    import scmd_pkg::*;
(
    input  logic [BYTE_W-1:0] op_i,
    output cmd_e              cmd_o
);
    always_comb begin
        case (op_i)
            OP_WREN:  cmd_o = CMD_LATCH_ON;
            OP_WRDI:  cmd_o = CMD_LATCH_OFF;
            OP_RDSR:  cmd_o = CMD_STS_RD;
            OP_WRSR:  cmd_o = CMD_STS_WR;
            OP_READ:  cmd_o = CMD_MEM_RD;
            OP_WRITE: cmd_o = CMD_MEM_WR;
            default:  cmd_o = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/scmd_array.sv
module scmd_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/scmd_txshift.sv
module scmd_txshift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic              quiet_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              miso_o,
    output logic              oe_o
);
    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              bit_out;
        logic              oe;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (clr_i) begin
            tx_d = '0;
        end else if (fall_i) begin
            if (load_i) begin
                tx_d.bit_out = data_i[DATA_W-1];
                tx_d.sh      = {data_i[DATA_W-2:0], 1'b0};
                tx_d.oe      = 1'b1;
            end else if (quiet_i) begin
                tx_d.oe      = 1'b0;
                tx_d.bit_out = 1'b0;
            end else begin
                tx_d.bit_out = tx_q.sh[DATA_W-1];
                tx_d.sh      = {tx_q.sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign miso_o = tx_q.bit_out & tx_q.oe;
    assign oe_o   = tx_q.oe;
endmodule

// File: rtl/scmd_engine.sv
module scmd_engine
    import scmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              mosi_i,
    input  logic              wr_allow_i,
    input  logic [7:0]        status_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [ADDR_W-1:0] chk_addr_o,
    output logic              set_wel_o,
    output logic              clr_wel_o,
    output logic              sts_wr_o,
    output logic [7:0]        sts_wdata_o
);
    localparam int HI_W    = ADDR_W - BYTE_W;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e            phase;
        cmd_e              cmd;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-2:0] rx;
        logic [HI_W-1:0]   adh;
        logic [ADDR_W-1:0] addr;
        logic              load_pend;
        logic              wr_frame;
        logic              set_wel;
        logic              clr_wel;
        logic              sts_wr;
        logic [BYTE_W-1:0] sts_data;
    } eng_t;

    eng_t st_d, st_q;

    logic [BYTE_W-1:0] in_byte;
    logic              byte_done;
    cmd_e              dec_cmd;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_rdata;
    logic [BYTE_W-1:0] tx_src;
    logic              tx_quiet;

    assign in_byte   = {st_q.rx, mosi_i};
    assign byte_done = sel_i && sck_rise_i && (st_q.bitcnt == LAST_BIT);

    scmd_decode u_decode (
        .op_i  (in_byte),
        .cmd_o (dec_cmd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.set_wel = 1'b0;
        st_d.clr_wel = 1'b0;
        st_d.sts_wr  = 1'b0;
        mem_we       = 1'b0;

        if (!sel_i) begin
            st_d.phase     = PH_OPC;
            st_d.cmd       = CMD_NONE;
            st_d.bitcnt    = '0;
            st_d.load_pend = 1'b0;
            st_d.clr_wel   = st_q.wr_frame;
            st_d.wr_frame  = 1'b0;
        end else begin
            if (sck_fall_i && st_q.load_pend) begin
                st_d.load_pend = 1'b0;
            end
            if (sck_rise_i) begin
                st_d.rx     = in_byte[BYTE_W-2:0];
                st_d.bitcnt = st_q.bitcnt + 1'b1;
            end
            if (byte_done) begin
                case (st_q.phase)
                    PH_OPC: begin
                        st_d.cmd = dec_cmd;
                        case (dec_cmd)
                            CMD_LATCH_ON: begin
                                st_d.set_wel = 1'b1;
                                st_d.phase   = PH_SKIP;
                            end
                            CMD_LATCH_OFF: begin
                                st_d.clr_wel = 1'b1;
                                st_d.phase   = PH_SKIP;
                            end
                            CMD_STS_RD: begin
                                st_d.phase     = PH_DATA;
                                st_d.load_pend = 1'b1;
                            end
                            CMD_STS_WR: begin
                                st_d.phase    = PH_DATA;
                                st_d.wr_frame = 1'b1;
                            end
                            CMD_MEM_RD: begin
                                st_d.phase = PH_ADH;
                            end
                            CMD_MEM_WR: begin
                                st_d.phase    = PH_ADH;
                                st_d.wr_frame = 1'b1;
                            end
                            default: begin
                                st_d.phase = PH_SKIP;
                            end
                        endcase
                    end
                    PH_ADH: begin
                        st_d.adh   = in_byte[HI_W-1:0];
                        st_d.phase = PH_ADL;
                    end
                    PH_ADL: begin
                        st_d.addr  = {st_q.adh, in_byte};
                        st_d.phase = PH_DATA;
                        if (st_q.cmd == CMD_MEM_RD) begin
                            st_d.load_pend = 1'b1;
                        end
                    end
                    PH_DATA: begin
                        case (st_q.cmd)
                            CMD_MEM_RD: begin
                                st_d.addr      = st_q.addr + 1'b1;
                                st_d.load_pend = 1'b1;
                            end
                            CMD_MEM_WR: begin
                                mem_we    = wr_allow_i;
                                st_d.addr = st_q.addr + 1'b1;
                            end
                            CMD_STS_WR: begin
                                st_d.sts_wr   = 1'b1;
                                st_d.sts_data = in_byte;
                                st_d.phase    = PH_SKIP;
                            end
                            default: begin
                                st_d.phase = PH_SKIP;
                            end
                        endcase
                    end
                    default: begin
                        st_d.phase = PH_SKIP;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    scmd_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (st_q.addr),
        .wdata_i (in_byte),
        .raddr_i (st_q.addr),
        .rdata_o (mem_rdata)
    );

    assign tx_src   = (st_q.cmd == CMD_STS_RD) ? status_i : mem_rdata;
    assign tx_quiet = (st_q.phase == PH_SKIP);

    scmd_txshift #(
        .DATA_W (BYTE_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!sel_i),
        .fall_i  (sck_fall_i),
        .load_i  (st_q.load_pend),
        .quiet_i (tx_quiet),
        .data_i  (tx_src),
        .miso_o  (miso_o),
        .oe_o    (miso_oe_o)
    );

    assign chk_addr_o  = st_q.addr;
    assign set_wel_o   = st_q.set_wel;
    assign clr_wel_o   = st_q.clr_wel;
    assign sts_wr_o    = st_q.sts_wr;
    assign sts_wdata_o = st_q.sts_data;
endmodule

// File: rtl/scmd_engine_chk.sv
module scmd_engine_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              sck_rise_i,
    input logic              sck_fall_i,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic [ADDR_W-1:0] chk_addr_o,
    input logic              set_wel_o,
    input logic              clr_wel_o,
    input logic              sts_wr_o
);
    p_pulse_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_wel_o, clr_wel_o, sts_wr_o}));

    p_set_after_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_wel_o |-> $past(sel_i && sck_rise_i));

    p_miso_only_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe_o && !$past(sck_fall_i)) |-> $stable(miso_o));

    p_sts_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_o |-> $past(sel_i && sck_rise_i));

    p_clr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wel_o |-> $past(!sel_i || sck_rise_i));

    p_quiet_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |-> !miso_o);

    p_release_on_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !miso_oe_o);

    p_addr_hold_desel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && $past(!sel_i)) |-> $stable(chk_addr_o));
endmodule

bind scmd_engine scmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .sck_rise_i (sck_rise_i),
    .sck_fall_i (sck_fall_i),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .chk_addr_o (chk_addr_o),
    .set_wel_o  (set_wel_o),
    .clr_wel_o  (clr_wel_o),
    .sts_wr_o   (sts_wr_o)
);

// File: tb/scmd_engine_bench.sv
module scmd_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] STATUS_VAL = 8'hB4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        rise = 1'b0;
    logic        fall = 1'b0;
    logic        mosi = 1'b0;
    logic        wr_allow;
    logic        miso_o, miso_oe_o;
    logic [10:0] chk_addr_o;
    logic        set_wel_o, clr_wel_o, sts_wr_o;
    logic [7:0]  sts_wdata_o;

    logic        prot_en = 1'b0;
    logic [10:0] prot_lo = '0;
    logic [10:0] prot_hi = '0;

    int checks = 0;
    int fails = 0;
    int set_cnt = 0;
    int clr_cnt = 0;
    int sts_cnt = 0;
    logic [7:0] sts_last = '0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign wr_allow = !(prot_en && chk_addr_o >= prot_lo && chk_addr_o <= prot_hi);

    scmd_engine u_scmd_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .sck_rise_i  (rise),
        .sck_fall_i  (fall),
        .mosi_i      (mosi),
        .wr_allow_i  (wr_allow),
        .status_i    (STATUS_VAL),
        .miso_o      (miso_o),
        .miso_oe_o   (miso_oe_o),
        .chk_addr_o  (chk_addr_o),
        .set_wel_o   (set_wel_o),
        .clr_wel_o   (clr_wel_o),
        .sts_wr_o    (sts_wr_o),
        .sts_wdata_o (sts_wdata_o)
    );

    always @(posedge clk) begin
        if (set_wel_o) set_cnt++;
        if (clr_wel_o) clr_cnt++;
        if (sts_wr_o) begin
            sts_cnt++;
            sts_last = sts_wdata_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (got_q.size() > 0) begin
            logic [7:0] g;
            g = got_q.pop_front();
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", g, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(g == e, t, g, e);
            end
        end
    end

    task automatic expect_byte(input logic [7:0] b, input string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic bit_x(input logic b, output logic r, output logic oe);
        @(negedge clk);
        mosi = b;
        r  = miso_o;
        oe = miso_oe_o;
        rise = 1'b1;
        @(negedge clk);
        rise = 1'b0;
        @(negedge clk);
        fall = 1'b1;
        @(negedge clk);
        fall = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            logic r, oe;
            bit_x(tx[i], r, oe);
            rx[i] = r;
            oe_any = oe_any | oe;
        end
    endtask

    task automatic open_frame();
        @(negedge clk);
        sel = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_frame();
        @(negedge clk);
        sel = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] rx;
        logic oe;
        xfer(b, rx, oe);
    endtask

    task automatic cmd_only(input logic [7:0] op);
        open_frame();
        send(op);
        close_frame();
    endtask

    task automatic write_burst(input logic [15:0] a, input logic [7:0] d [4], input int n);
        open_frame();
        send(8'h02);
        send(a[15:8]);
        send(a[7:0]);
        for (int i = 0; i < n; i++) send(d[i]);
        close_frame();
    endtask

    task automatic read_burst(input logic [15:0] a, input int n);
        logic [7:0] rx;
        logic oe;
        open_frame();
        send(8'h03);
        send(a[15:8]);
        send(a[7:0]);
        for (int i = 0; i < n; i++) begin
            xfer(8'hFF, rx, oe);
            got_q.push_back(rx);
            chk(oe == 1'b1, "R5 drive enable during read", oe, 1);
        end
        close_frame();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d [4];
        logic [7:0] rx;
        logic oe;
        int c0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(miso_oe_o == 1'b0, "reset: output released (R10)", miso_oe_o, 0);
        chk(miso_o == 1'b0, "reset: data out low (R10)", miso_o, 0);

        cmd_only(8'h06);
        chk(set_cnt == 1, "R1 latch-on pulse", set_cnt, 1);

        open_frame();
        send(8'h06);
        send(8'h04);
        close_frame();
        chk(set_cnt == 2 && clr_cnt == 0, "R2 second byte not decoded", clr_cnt, 0);

        cmd_only(8'h04);
        chk(clr_cnt == 1, "R1 latch-off pulse", clr_cnt, 1);

        d = '{8'h11, 8'h22, 8'h33, 8'h00};
        write_burst(16'hF810, d, 3);
        chk(clr_cnt == 2, "R9 write frame end clears latch", clr_cnt, 2);
        expect_byte(8'h11, "R4 readback 0x010");
        expect_byte(8'h22, "R4 readback 0x011");
        expect_byte(8'h33, "R5 burst byte 0x012");
        read_burst(16'h0010, 3);
        expect_byte(8'h11, "R3 upper address bits ignored");
        read_burst(16'hA810, 1);

        d = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
        write_burst(16'h07FE, d, 4);
        expect_byte(8'hA2, "R6 top address");
        expect_byte(8'hA3, "R6 write wrapped to 0x000");
        expect_byte(8'hA4, "R6 read wrapped to 0x001");
        read_burst(16'h07FF, 3);

        d = '{8'hEE, 8'hEF, 8'h00, 8'h00};
        write_burst(16'h0100, d, 2);
        d = '{8'h3C, 8'h00, 8'h00, 8'h00};
        write_burst(16'h0021, d, 1);

        prot_en = 1'b1;
        prot_lo = 11'h100;
        prot_hi = 11'h100;
        d = '{8'h61, 8'h62, 8'h63, 8'h00};
        write_burst(16'h00FF, d, 3);
        prot_en = 1'b0;
        expect_byte(8'h61, "R7 allowed byte before window");
        expect_byte(8'hEE, "R7 refused byte dropped");
        expect_byte(8'h63, "R7 address advanced past refused byte");
        read_burst(16'h00FF, 3);

        open_frame();
        send(8'h05);
        xfer(8'h00, rx, oe);
        chk(rx == STATUS_VAL, "R8 status byte", rx, STATUS_VAL);
        xfer(8'h00, rx, oe);
        chk(oe == 1'b0, "R8 released after one byte", oe, 0);
        close_frame();

        c0 = clr_cnt;
        open_frame();
        send(8'h01);
        send(8'h5A);
        close_frame();
        chk(sts_cnt == 1 && sts_last == 8'h5A, "R9 status write byte", sts_last, 8'h5A);
        chk(clr_cnt == c0 + 1, "R9 status write frame end", clr_cnt, c0 + 1);

        c0 = clr_cnt;
        open_frame();
        xfer(8'h07, rx, oe);
        xfer(8'h00, rx, oe);
        chk(oe == 1'b0, "R10 undriven after unknown op", oe, 1'b0);
        xfer(8'h10, rx, oe);
        xfer(8'h99, rx, oe);
        chk(oe == 1'b0, "R10 still undriven", oe, 1'b0);
        close_frame();
        chk(set_cnt == 2 && clr_cnt == c0 && sts_cnt == 1, "R10 no pulses", clr_cnt, c0);
        expect_byte(8'h11, "R10 memory untouched");
        read_burst(16'h0010, 1);
        expect_byte(8'h11, "R5 SI ignored during read");
        read_burst(16'h0010, 1);

        open_frame();
        send(8'h02);
        send(8'h00);
        send(8'h20);
        send(8'h77);
        for (int i = 0; i < 4; i++) bit_x(1'b1, rx[0], oe);
        close_frame();
        expect_byte(8'h77, "R11 full byte kept");
        expect_byte(8'h3C, "R11 partial byte not stored");
        read_burst(16'h0020, 2);
        cmd_only(8'h06);
        chk(set_cnt == 3, "R11 fresh decode after abort", set_cnt, 3);

        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            mosi = OP_BITS(i);
            rise = 1'b1;
            @(negedge clk);
            rise = 1'b0;
            fall = 1'b1;
            @(negedge clk);
            fall = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(set_cnt == 3 && miso_oe_o == 1'b0, "R12 strobes ignored when deselected", set_cnt, 3);
        cmd_only(8'h06);
        chk(set_cnt == 4, "R12 next frame starts clean", set_cnt, 4);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

    function automatic logic OP_BITS(input int i);
        logic [7:0] v;
        v = 8'h06;
        return v[i];
    endfunction
endmodule